// File: doc/BRIEF.md
# Video line timing and sync generator

This block sets the line and frame cadence of a video-mode stream on a multi-lane serial display link. All timing is counted in byte-clock cycles. The period of one line comes from a programmed blanking-packet byte count plus a fixed six-byte overhead, spread over the active lanes and rounded up to a whole cycle. Because of the rounding, every line in a frame lasts exactly the same number of cycles and the timing never falls short of the bytes it has to carry.

Lines are grouped into four vertical regions: sync, back porch, active and front porch. The block steps through them in that order and starts again after the last region. On the first cycle of each line it issues a line-start strobe, with horizontal and vertical sync event strobes according to the mode controls. It also holds a flag for the whole line when the programmed wake-up time fits inside the line period, so a downstream link controller knows that it may drop to low power. The configuration inputs are captured when the block starts and at every frame boundary, so a change made in the middle of a frame applies from the next frame on.

Top module: `vid_line_timer`

## Requirements
- R1: The line period in cycles is ceil(L / N), where N is the effective lane count and L = P + 6. P is `blk_pulse_pck` when `pulse_mode`=1 and `blk_event_pck` when `pulse_mode`=0. Consecutive `line_start` strobes are exactly that many cycles apart.
- R2: When `pulse_mode`=0, `burst_lp`=1, `lanes`=2, `hsa_len_lsb`=1 and `hfp_len_lsb`=1 all hold, L is reduced by 1 before the division. In every other case L is left unchanged.
- R3: The effective lane count N is 1 when `lanes` is 0, the value of `lanes` when it is 1 to 4, and 4 when it is 5 to 7.
- R4: A frame consists of `vsa_lines`, then `vbp_lines`, then `act_lines`, then `vfp_lines` lines, and then the next frame begins. A region with a count of 0 is skipped. If all four counts are 0, the frame is a single active line. `line_start` is high on the first cycle of every line and on no other cycle.
- R5: `line_active` is high on every cycle of the active-region lines and low on every other cycle.
- R6: `hsync_evt` pulses with `line_start` on every line when `sync_horiz`=1. When `sync_horiz`=0 and `sync_active`=1, it pulses only on active lines. When both are 0, it never pulses.
- R7: `vsync_evt` pulses with `line_start` on every line of the vertical sync region and on no other line.
- R8: `lp_ok` is high on every cycle of a running frame exactly when `wakeup_time` is strictly less than the line period of that frame.
- R9: One cycle after a `start` pulse, the first line of the first frame begins. All configuration inputs are captured at that start and again at each frame boundary, so a change made within a frame first takes effect on the following frame. Frames follow each other with no gap.
- R10: During and after reset, and until `start` is seen, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin frame generation (ignored once running) |
| pulse_mode | input | 1 | 1 selects the pulse-mode blanking count, 0 the event-mode count |
| burst_lp | input | 1 | Burst with low-power enabled (for the event-mode correction) |
| lanes | input | 3 | Programmed lane count |
| hsa_len_lsb | input | 1 | Bit 0 of the horizontal sync byte length |
| hfp_len_lsb | input | 1 | Bit 0 of the horizontal front porch byte length |
| blk_pulse_pck | input | 16 | Blanking-line payload bytes, pulse mode |
| blk_event_pck | input | 16 | Blanking-line payload bytes, event mode |
| sync_horiz | input | 1 | HSYNC on every line |
| sync_active | input | 1 | HSYNC on active lines |
| vsa_lines | input | 12 | Vertical sync region lines |
| vbp_lines | input | 12 | Vertical back porch lines |
| act_lines | input | 12 | Active lines |
| vfp_lines | input | 12 | Vertical front porch lines |
| wakeup_time | input | 16 | Wake-up interval in cycles |
| line_start | output | 1 | First cycle of each line |
| hsync_evt | output | 1 | Horizontal sync event strobe |
| vsync_evt | output | 1 | Vertical sync event strobe |
| line_active | output | 1 | Current line is an active line |
| lp_ok | output | 1 | Low-power entry allowed in this line |

## Verification
The last cycle of the final line of a frame falls in the same cycle as the capture of the next frame's configuration. The bench provokes this by changing the blanking count in the middle of a frame. It then judges that the remaining lines still follow the old period and that the first line of the next frame, which starts on the very next cycle, already follows the new one. A second coincidence is a vertical sync line that is also the start of a new frame. Sweeps over the region counts, including empty regions, check that `vsync_evt`, `hsync_evt` and `line_start` arrive together on the first cycle after each wrap.

// File: rtl/vlt_pkg.sv
package vlt_pkg;

    typedef enum logic [1:0] {
        RG_VSA = 2'd0,
        RG_VBP = 2'd1,
        RG_ACT = 2'd2,
        RG_VFP = 2'd3
    } region_t;

    localparam int NUM_REGIONS = 4;
    localparam int LINE_OVERHEAD = 6;

    // Lane count seen by the divider: 0 -> 1, above 4 -> 4
    function automatic int unsigned eff_lanes(input logic [2:0] raw);
        if (raw == 3'd0)
            return 1;
        else if (raw > 3'd4)
            return 4;
        else
            return int'(raw);
    endfunction

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    // First region index >= from whose mask bit is set; 4 when none
    function automatic logic [2:0] first_nz(input logic [3:0] nz, input logic [2:0] from);
        logic [2:0] r;
        r = 3'd4;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (nz[i] && (3'(i) >= from))
                r = 3'(i);
        end
        return r;
    endfunction

endpackage

// File: rtl/vlt_cfg_shadow.sv
module vlt_cfg_shadow
    import vlt_pkg::*;
#(
    parameter int BYTE_W = 16,
    parameter int LINE_W = 12,
    localparam int CYC_W = BYTE_W + 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load,
    input  logic                          pulse_mode,
    input  logic                          burst_lp,
    input  logic [2:0]                    lanes,
    input  logic                          hsa_len_lsb,
    input  logic                          hfp_len_lsb,
    input  logic [BYTE_W-1:0]             blk_pulse_pck,
    input  logic [BYTE_W-1:0]             blk_event_pck,
    input  logic                          sync_horiz,
    input  logic                          sync_active,
    input  logic [NUM_REGIONS-1:0][LINE_W-1:0] cnt_raw,
    input  logic [BYTE_W-1:0]             wakeup_time,
    output logic [NUM_REGIONS-1:0][LINE_W-1:0] cnt_new,
    output logic [NUM_REGIONS-1:0][LINE_W-1:0] cnt_sh,
    output logic [CYC_W-1:0]              dur_sh,
    output logic                          hs_all_sh,
    output logic                          hs_act_sh,
    output logic                          lp_sh
);

    logic [CYC_W-1:0] len;
    logic [CYC_W-1:0] dur_next;
    logic [3:0]       nz;

    always_comb begin
        len = pulse_mode ? {1'b0, blk_pulse_pck} : {1'b0, blk_event_pck};
        len = len + CYC_W'(LINE_OVERHEAD);
        if (!pulse_mode && burst_lp && (lanes == 3'd2) && hsa_len_lsb && hfp_len_lsb)
            len = len - CYC_W'(1);
        dur_next = CYC_W'(ceil_div(32'(len), eff_lanes(lanes)));
    end

    // Empty frame collapses to one active line
    generate
        for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_nz
            assign nz[g] = (cnt_raw[g] != '0);
        end
    endgenerate

    always_comb begin
        cnt_new = cnt_raw;
        if (nz == 4'd0)
            cnt_new[RG_ACT] = LINE_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_sh    <= '0;
            dur_sh    <= CYC_W'(1);
            hs_all_sh <= 1'b0;
            hs_act_sh <= 1'b0;
            lp_sh     <= 1'b0;
        end else if (load) begin
            cnt_sh    <= cnt_new;
            dur_sh    <= dur_next;
            hs_all_sh <= sync_horiz;
            hs_act_sh <= sync_active;
            lp_sh     <= ({1'b0, wakeup_time} < dur_next);
        end
    end

endmodule

// File: rtl/vlt_line_counter.sv
module vlt_line_counter #(
    parameter int CYC_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [CYC_W-1:0] dur,
    output logic [CYC_W-1:0] cyc,
    output logic             last
);

    assign last = run && (cyc == dur - CYC_W'(1));

    always_ff @(posedge clk) begin
        if (rst)
            cyc <= '0;
        else if (restart || last)
            cyc <= '0;
        else if (run)
            cyc <= cyc + CYC_W'(1);
    end

endmodule

// File: rtl/vlt_frame_seq.sv
module vlt_frame_seq
    import vlt_pkg::*;
#(
    parameter int LINE_W = 12
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               load,
    input  logic                               line_end,
    input  logic [NUM_REGIONS-1:0][LINE_W-1:0] cnt_sh,
    input  logic [NUM_REGIONS-1:0][LINE_W-1:0] cnt_new,
    output region_t                            region,
    output logic                               frame_end
);

    logic [LINE_W-1:0] lcnt;
    logic [3:0]        nz_sh;
    logic [3:0]        nz_new;
    logic [2:0]        after;
    logic              last_line;

    generate
        for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_mask
            assign nz_sh[g]  = (cnt_sh[g] != '0);
            assign nz_new[g] = (cnt_new[g] != '0);
        end
    endgenerate

    assign after     = first_nz(nz_sh, 3'({1'b0, region}) + 3'd1);
    assign last_line = (lcnt == cnt_sh[region] - LINE_W'(1));
    assign frame_end = line_end && last_line && (after == 3'd4);

    always_ff @(posedge clk) begin
        if (rst) begin
            region <= RG_VSA;
            lcnt   <= '0;
        end else if (load) begin
            region <= region_t'(first_nz(nz_new, 3'd0));
            lcnt   <= '0;
        end else if (line_end) begin
            if (!last_line) begin
                lcnt <= lcnt + LINE_W'(1);
            end else begin
                region <= region_t'(after);
                lcnt   <= '0;
            end
        end
    end

endmodule

// File: rtl/vid_line_timer.sv
module vid_line_timer
    import vlt_pkg::*;
#(
    parameter int BYTE_W = 16,
    parameter int LINE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              pulse_mode,
    input  logic              burst_lp,
    input  logic [2:0]        lanes,
    input  logic              hsa_len_lsb,
    input  logic              hfp_len_lsb,
    input  logic [BYTE_W-1:0] blk_pulse_pck,
    input  logic [BYTE_W-1:0] blk_event_pck,
    input  logic              sync_horiz,
    input  logic              sync_active,
    input  logic [LINE_W-1:0] vsa_lines,
    input  logic [LINE_W-1:0] vbp_lines,
    input  logic [LINE_W-1:0] act_lines,
    input  logic [LINE_W-1:0] vfp_lines,
    input  logic [BYTE_W-1:0] wakeup_time,
    output logic              line_start,
    output logic              hsync_evt,
    output logic              vsync_evt,
    output logic              line_active,
    output logic              lp_ok
);

    localparam int CYC_W = BYTE_W + 1;

    logic                               running;
    logic                               load;
    logic                               frame_end;
    logic                               line_end;
    logic [CYC_W-1:0]                   cyc;
    logic [CYC_W-1:0]                   dur_sh;
    logic [NUM_REGIONS-1:0][LINE_W-1:0] cnt_raw;
    logic [NUM_REGIONS-1:0][LINE_W-1:0] cnt_new;
    logic [NUM_REGIONS-1:0][LINE_W-1:0] cnt_sh;
    logic                               hs_all_sh;
    logic                               hs_act_sh;
    logic                               lp_sh;
    region_t                            region;

    assign cnt_raw[RG_VSA] = vsa_lines;
    assign cnt_raw[RG_VBP] = vbp_lines;
    assign cnt_raw[RG_ACT] = act_lines;
    assign cnt_raw[RG_VFP] = vfp_lines;

    assign load = (start && !running) || frame_end;

    always_ff @(posedge clk) begin
        if (rst)
            running <= 1'b0;
        else if (start)
            running <= 1'b1;
    end

    vlt_cfg_shadow #(.BYTE_W(BYTE_W), .LINE_W(LINE_W)) u_cfg (
        .clk           (clk),
        .rst           (rst),
        .load          (load),
        .pulse_mode    (pulse_mode),
        .burst_lp      (burst_lp),
        .lanes         (lanes),
        .hsa_len_lsb   (hsa_len_lsb),
        .hfp_len_lsb   (hfp_len_lsb),
        .blk_pulse_pck (blk_pulse_pck),
        .blk_event_pck (blk_event_pck),
        .sync_horiz    (sync_horiz),
        .sync_active   (sync_active),
        .cnt_raw       (cnt_raw),
        .wakeup_time   (wakeup_time),
        .cnt_new       (cnt_new),
        .cnt_sh        (cnt_sh),
        .dur_sh        (dur_sh),
        .hs_all_sh     (hs_all_sh),
        .hs_act_sh     (hs_act_sh),
        .lp_sh         (lp_sh)
    );

    vlt_line_counter #(.CYC_W(CYC_W)) u_lc (
        .clk     (clk),
        .rst     (rst),
        .run     (running),
        .restart (load),
        .dur     (dur_sh),
        .cyc     (cyc),
        .last    (line_end)
    );

    vlt_frame_seq #(.LINE_W(LINE_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .line_end  (line_end),
        .cnt_sh    (cnt_sh),
        .cnt_new   (cnt_new),
        .region    (region),
        .frame_end (frame_end)
    );

    assign line_start  = running && (cyc == '0);
    assign line_active = running && (region == RG_ACT);
    assign hsync_evt   = line_start && (hs_all_sh || (hs_act_sh && region == RG_ACT));
    assign vsync_evt   = line_start && (region == RG_VSA);
    assign lp_ok       = running && lp_sh;

endmodule

// File: rtl/vlt_checker.sv
module vlt_checker (
    input logic clk,
    input logic rst,
    input logic line_start,
    input logic hsync_evt,
    input logic vsync_evt,
    input logic line_active,
    input logic lp_ok
);

    // R6: horizontal events only at the start of a line
    p_hsync_at_start_r6: assert property (@(posedge clk) disable iff (rst)
        hsync_evt |-> line_start);

    // R7: vertical events only at the start of a non-active line
    p_vsync_in_blank_r7: assert property (@(posedge clk) disable iff (rst)
        vsync_evt |-> (line_start && !line_active));

    // R5: the active flag only changes at a line boundary
    p_active_stable_r5: assert property (@(posedge clk) disable iff (rst)
        !line_start |-> $stable(line_active));

    // R8: the low-power flag holds across a line
    p_lp_stable_r8: assert property (@(posedge clk) disable iff (rst)
        !line_start |-> $stable(lp_ok));

    // R1: the shortest line period is two cycles
    p_min_period_r1: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !line_start);

endmodule

bind vid_line_timer vlt_checker u_vlt_checker (
    .clk         (clk),
    .rst         (rst),
    .line_start  (line_start),
    .hsync_evt   (hsync_evt),
    .vsync_evt   (vsync_evt),
    .line_active (line_active),
    .lp_ok       (lp_ok)
);

// File: tb/vid_line_timer_bench.sv
module vid_line_timer_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        pulse_mode = 1'b0;
    logic        burst_lp = 1'b0;
    logic [2:0]  lanes = 3'd1;
    logic        hsa_len_lsb = 1'b0;
    logic        hfp_len_lsb = 1'b0;
    logic [15:0] blk_pulse_pck = '0;
    logic [15:0] blk_event_pck = '0;
    logic        sync_horiz = 1'b0;
    logic        sync_active = 1'b0;
    logic [11:0] vsa_lines = '0;
    logic [11:0] vbp_lines = '0;
    logic [11:0] act_lines = '0;
    logic [11:0] vfp_lines = '0;
    logic [15:0] wakeup_time = '0;
    logic        line_start, hsync_evt, vsync_evt, line_active, lp_ok;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_line_timer u_vid_line_timer (
        .clk(clk), .rst(rst), .start(start), .pulse_mode(pulse_mode),
        .burst_lp(burst_lp), .lanes(lanes), .hsa_len_lsb(hsa_len_lsb),
        .hfp_len_lsb(hfp_len_lsb), .blk_pulse_pck(blk_pulse_pck),
        .blk_event_pck(blk_event_pck), .sync_horiz(sync_horiz),
        .sync_active(sync_active), .vsa_lines(vsa_lines), .vbp_lines(vbp_lines),
        .act_lines(act_lines), .vfp_lines(vfp_lines), .wakeup_time(wakeup_time),
        .line_start(line_start), .hsync_evt(hsync_evt), .vsync_evt(vsync_evt),
        .line_active(line_active), .lp_ok(lp_ok)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_dur();
        int ln, len;
        ln  = (lanes == 0) ? 1 : ((lanes > 4) ? 4 : int'(lanes));
        len = (pulse_mode ? int'(blk_pulse_pck) : int'(blk_event_pck)) + 6;
        if (!pulse_mode && burst_lp && lanes == 3'd2 && hsa_len_lsb && hfp_len_lsb)
            len = len - 1;
        return (len + ln - 1) / ln;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        start = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic kick();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Called at the negedge of cycle 0 of a frame; returns at cycle 0 of the next
    task automatic measure(input string tag);
        int d, a, b, c, e, tot, n;
        int ls_bad, act_bad, lp_bad, hs_n, vs_n;
        bit lp_exp;
        d = exp_dur();
        a = int'(vsa_lines); b = int'(vbp_lines);
        c = int'(act_lines); e = int'(vfp_lines);
        if (a + b + c + e == 0) c = 1;
        tot = a + b + c + e;
        n = d * tot;
        lp_exp = (int'(wakeup_time) < d);
        ls_bad = 0; act_bad = 0; lp_bad = 0; hs_n = 0; vs_n = 0;
        for (int k = 0; k < n; k++) begin
            if (line_start != ((k % d) == 0)) ls_bad++;
            if (line_active != ((k >= (a + b) * d) && (k < (a + b + c) * d))) act_bad++;
            if (lp_ok != lp_exp) lp_bad++;
            if (hsync_evt) hs_n++;
            if (vsync_evt) vs_n++;
            @(negedge clk);
        end
        check(ls_bad == 0, {"R1 R2 R3 R4 line period ", tag}, ls_bad, 0);
        check(act_bad == 0, {"R5 active window ", tag}, act_bad, 0);
        check(lp_bad == 0, {"R8 lp flag ", tag}, lp_bad, 0);
        check(hs_n == (sync_horiz ? tot : (sync_active ? c : 0)), {"R6 hsync count ", tag},
              hs_n, sync_horiz ? tot : (sync_active ? c : 0));
        check(vs_n == a, {"R7 vsync count ", tag}, vs_n, a);
        check(line_start == 1'b1, {"R9 frame wrap ", tag}, int'(line_start), 1);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin : stim
        int pcks[5];
        int idx;
        pcks = '{0, 1, 7, 13, 40};

        // R10: reset state and idle before start
        do_reset();
        repeat (3) @(negedge clk);
        check({line_start, hsync_evt, vsync_evt, line_active, lp_ok} == 5'd0,
              "R10 idle outputs", int'({line_start, hsync_evt, vsync_evt, line_active, lp_ok}), 0);

        idx = 0;
        for (int ln = 0; ln < 8; ln++) begin
            for (int pi = 0; pi < 5; pi++) begin
                for (int m = 0; m < 4; m++) begin
                    do_reset();
                    lanes = 3'(ln);
                    pulse_mode = m[0];
                    burst_lp = 1'b1;
                    hsa_len_lsb = 1'b1;
                    hfp_len_lsb = m[1];
                    blk_pulse_pck = 16'(pcks[pi] + 3);
                    blk_event_pck = 16'(pcks[pi]);
                    sync_horiz = idx[0];
                    sync_active = idx[1];
                    vsa_lines = 12'(idx % 3);
                    vbp_lines = 12'((idx / 3) % 3);
                    act_lines = 12'(1 + (idx % 2));
                    vfp_lines = 12'((idx / 2) % 3);
                    wakeup_time = 16'(exp_dur() - 1 + (idx % 3));
                    check({line_start, line_active, lp_ok} == 3'd0, "R10 before start",
                          int'({line_start, line_active, lp_ok}), 0);
                    kick();
                    measure($sformatf("lanes=%0d pck=%0d m=%0d", ln, pcks[pi], m));
                    idx++;
                end
            end
        end

        // R4: all region counts zero -> one active line
        do_reset();
        lanes = 3'd2; pulse_mode = 1'b0; burst_lp = 1'b0;
        blk_event_pck = 16'd5; sync_horiz = 1'b0; sync_active = 1'b1;
        vsa_lines = '0; vbp_lines = '0; act_lines = '0; vfp_lines = '0;
        wakeup_time = 16'd100;
        kick();
        measure("R4 empty frame");
        measure("R4 empty frame second");

        // R9: mid-frame change applies on the next frame only
        do_reset();
        lanes = 3'd1; pulse_mode = 1'b0; burst_lp = 1'b0;
        blk_event_pck = 16'd4; sync_horiz = 1'b1; sync_active = 1'b0;
        vsa_lines = 12'd1; vbp_lines = 12'd1; act_lines = 12'd2; vfp_lines = 12'd1;
        wakeup_time = 16'd3;
        kick();
        begin
            int bad;
            bad = 0;
            for (int k = 0; k < 50; k++) begin
                if (k == 7) begin
                    blk_event_pck = 16'd10;
                    wakeup_time = 16'd20;
                end
                if (line_start != ((k % 10) == 0)) bad++;
                if (lp_ok != 1'b1) bad++;
                @(negedge clk);
            end
            check(bad == 0, "R9 old config held to frame end", bad, 0);
        end
        measure("R9 new config next frame");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule